// File: doc/BRIEF.md
# Six-Mode Shift and Rotate Unit

This block moves the bits of a data word by a variable distance in one of six ways. Logical and arithmetic shifts can go in either direction, and rotates can go in either direction. A three-bit operation code selects the mode. The shift distance is an unsigned field that is log2 of the word width wide, so every value it can hold is a legal distance.

The datapath itself is combinational: a logarithmic barrel of right-going stages. A conditional bit reversal sits in front of the barrel and another behind it, so the same stages also serve the left-going modes. The block registers the result once.

- A request is accepted when `in_valid` is high.
- Its result appears on `dout` one clock later, with `out_valid` marking it.
- While no request is present, `dout` keeps its last value.

The word width is a parameter and must be a power of two.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code 3'b000 (logical left) moves bits toward the MSB and writes 0 into the vacated low positions; 8'h95 by 2 gives 8'h54.
- R2: Operation code 3'b001 (logical right) moves bits toward the LSB and writes 0 into the vacated high positions; 8'h95 by 3 gives 8'h12.
- R3: Operation code 3'b010 (arithmetic left) moves bits toward the MSB and fills the vacated low positions with copies of the input's bit 0; 8'h95 by 3 gives 8'hAF.
- R4: Operation code 3'b011 (arithmetic right) moves bits toward the LSB and fills the vacated high positions with copies of the input's MSB; 8'h95 by 2 gives 8'hE5.
- R5: Operation code 3'b100 (rotate left) returns bits leaving the MSB into the LSB end; 8'h95 by 3 gives 8'hAC, and the number of ones is preserved.
- R6: Operation code 3'b101 (rotate right) returns bits leaving the LSB into the MSB end; 8'h95 by 5 gives 8'hAC and by 1 gives 8'hCA.
- R7: Operation codes 3'b110 and 3'b111 return the input word unchanged whatever the shift distance.
- R8: A shift distance of 0 returns the input word unchanged under every operation code.
- R9: `out_valid` equals the value `in_valid` had one clock earlier, and the result of a request accepted at one rising edge is on `dout` after that edge.
- R10: A synchronous active-high `rst` clears `dout` and `out_valid` to 0 at the next rising edge, and takes priority over `in_valid`.
- R11: While `in_valid` is low, `dout` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 3 | Operation select (see R1 to R7) |
| shamt | input | $clog2(W) | Shift or rotate distance |
| din | input | W | Data word to move |
| out_valid | output | 1 | Registered result valid |
| dout | output | W | Registered result |

## Verification
The hardest case to reach from the ports is a fill bit that differs from the bits next to it. Examples are an arithmetic left shift of a word whose bit 0 differs from bit 1, or a rotate whose wrapped bits differ from the bits they displace. Only then do a wrong fill source or a wrong wrap show up. The stimulus reaches these cases in two ways:
- It sweeps every operation code against every distance over many random words from a fixed seed, so each fill and wrap pattern occurs.
- It applies the fixed example vector 8'h95, whose ends are both 1 with 0 neighbours.

Separate idle and reset steps observe `dout` after cycles in which no request was accepted.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [2:0] {
    OP_SHL_LOG = 3'b000,
    OP_SHR_LOG = 3'b001,
    OP_SHL_ARI = 3'b010,
    OP_SHR_ARI = 3'b011,
    OP_ROT_L   = 3'b100,
    OP_ROT_R   = 3'b101,
    OP_PASS_A  = 3'b110,
    OP_PASS_B  = 3'b111
  } sru_op_e;

  typedef struct packed {
    logic to_left;
    logic rotate;
    logic arith;
    logic bypass;
  } sru_ctrl_t;

  function automatic sru_ctrl_t sru_decode(input logic [2:0] code);
    sru_ctrl_t c;
    c = '0;
    case (sru_op_e'(code))
      OP_SHL_LOG: c.to_left = 1'b1;
      OP_SHR_LOG: c.to_left = 1'b0;
      OP_SHL_ARI: begin c.to_left = 1'b1; c.arith  = 1'b1; end
      OP_SHR_ARI: c.arith = 1'b1;
      OP_ROT_L:   begin c.to_left = 1'b1; c.rotate = 1'b1; end
      OP_ROT_R:   c.rotate = 1'b1;
      default:    c.bypass = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sru_reverse.sv
module sru_reverse #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] flipped;

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flipped[i] = din[W-1-i];
  end

  assign dout = en ? flipped : din;
endmodule

// File: rtl/sru_barrel_right.sv
module sru_barrel_right #(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          rotate,
  input  logic          fill,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [AW+1];

  assign stg[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    assign moved    = rotate ? {stg[k][S-1:0], stg[k][W-1:S]}
                             : {{S{fill}}, stg[k][W-1:S]};
    assign stg[k+1] = amt[k] ? moved : stg[k];
  end

  assign dout = stg[AW];
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    op_code,
  input  logic [AW-1:0] shamt,
  input  logic [W-1:0]  din,
  output logic          out_valid,
  output logic [W-1:0]  dout
);
  import sru_pkg::*;

  sru_ctrl_t     ctrl;
  logic [AW-1:0] eff_amt;
  logic [W-1:0]  pre;
  logic [W-1:0]  moved;
  logic [W-1:0]  post;
  logic          fill_bit;

  assign ctrl    = sru_decode(op_code);
  assign eff_amt = ctrl.bypass ? '0 : shamt;

  // Left modes run through the right-going barrel on a mirrored word.
  sru_reverse #(.W(W)) u_rev_in (
    .en(ctrl.to_left), .din(din), .dout(pre)
  );

  // The mirrored MSB is the original LSB, which covers the arithmetic left fill.
  assign fill_bit = ctrl.arith & pre[W-1];

  sru_barrel_right #(.W(W), .AW(AW)) u_barrel (
    .din(pre), .amt(eff_amt), .rotate(ctrl.rotate),
    .fill(fill_bit), .dout(moved)
  );

  sru_reverse #(.W(W)) u_rev_out (
    .en(ctrl.to_left), .din(moved), .dout(post)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dout <= post;
    end
  end
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    op_code,
  input logic [AW-1:0] shamt,
  input logic [W-1:0]  din,
  input logic          out_valid,
  input logic [W-1:0]  dout
);
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && dout == '0));

  p_zero_amount_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shamt == '0) |=> dout == $past(din));

  p_pass_codes_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code[2:1] == 2'b11) |=> dout == $past(din));

  p_rotate_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code[2:1] == 2'b10) |=> $countones(dout) == $countones($past(din)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dout));

  p_lsl_zero_low_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 3'b000 && shamt != '0) |=> dout[0] == 1'b0);
endmodule

bind shift_rotate_unit sru_checker #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
  .shamt(shamt), .din(din), .out_valid(out_valid), .dout(dout)
);

// File: tb/shift_rotate_unit_tb.sv
`timescale 1ns/1ps
module shift_rotate_unit_tb;
  localparam int W  = 8;
  localparam int AW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    op_code = '0;
  logic [AW-1:0] shamt = '0;
  logic [W-1:0]  din = '0;
  logic          out_valid;
  logic [W-1:0]  dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  shift_rotate_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .shamt(shamt), .din(din), .out_valid(out_valid), .dout(dout)
  );

  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] ref_op(input logic [2:0] op, input int amt,
                                          input logic [W-1:0] d);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      case (op)
        3'd0: r[i] = (i >= amt) ? d[i-amt] : 1'b0;
        3'd1: r[i] = (i + amt < W) ? d[i+amt] : 1'b0;
        3'd2: r[i] = (i >= amt) ? d[i-amt] : d[0];
        3'd3: r[i] = (i + amt < W) ? d[i+amt] : d[W-1];
        3'd4: r[i] = d[(i - amt + W) % W];
        3'd5: r[i] = d[(i + amt) % W];
        default: r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] op, input int amt);
    if (amt == 0) return "R8";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (one rising edge between).
  task automatic run_op(input logic [2:0] op, input int amt, input logic [W-1:0] d);
    op_code  = op;
    shamt    = AW'(amt);
    din      = d;
    in_valid = 1'b1;
    @(negedge clk);
    check(req_of(op, amt), dout, ref_op(op, amt, d));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd1234));
    @(negedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10", {7'd0, out_valid}, 8'd0);
    check("R10", dout, 8'd0);
    rst = 1'b0;

    // Fixed example vectors: R1..R6
    run_op(3'd0, 2, 8'h95); check("R1", dout, 8'h54);
    run_op(3'd1, 3, 8'h95); check("R2", dout, 8'h12);
    run_op(3'd2, 3, 8'h95); check("R3", dout, 8'hAF);
    run_op(3'd3, 2, 8'h95); check("R4", dout, 8'hE5);
    run_op(3'd4, 3, 8'h95); check("R5", dout, 8'hAC);
    run_op(3'd5, 5, 8'h95); check("R6", dout, 8'hAC);
    run_op(3'd5, 1, 8'h95); check("R6", dout, 8'hCA);
    // R9: valid one cycle after accepted request
    check("R9", {7'd0, out_valid}, 8'd1);

    // Directed corners: arithmetic-left fill with 0 and with 1, pass codes with a large distance (R7)
    run_op(3'd2, 7, 8'h80);
    run_op(3'd2, 7, 8'h01);
    run_op(3'd6, 5, 8'h3C);
    run_op(3'd7, 7, 8'hC3);

    // Full sweep over codes and distances with random words
    for (int n = 0; n < 24; n++) begin
      logic [W-1:0] w;
      w = W'($urandom);
      for (int op = 0; op < 8; op++)
        for (int a = 0; a < W; a++)
          run_op(3'(op), a, w);
    end

    // R11: idle cycles keep the result while the inputs change; R9: valid drops
    held     = dout;
    in_valid = 1'b0;
    din      = ~held;
    op_code  = 3'd4;
    shamt    = 3'd1;
    @(negedge clk);
    check("R11", dout, held);
    check("R9", {7'd0, out_valid}, 8'd0);
    @(negedge clk);
    check("R11", dout, held);

    // R10: reset takes priority over a valid request
    run_op(3'd6, 0, 8'hFF);
    rst      = 1'b1;
    in_valid = 1'b1;
    din      = 8'h5A;
    @(negedge clk);
    check("R10", dout, 8'h00);
    check("R10", {7'd0, out_valid}, 8'd0);
    rst      = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule